// File: doc/BRIEF.md
# Multi-Mode Timer Capture/Compare Channel

A single 16-bit timer channel that changes personality by a 7-bit mode code. It can act as a plain input pin with an edge flag, a plain output pin, an edge-triggered capture unit, a pulse-width meter, a buffered modulus counter or a buffered PWM generator. Each of the two data registers (A and B) has a write-side stage (A2, B2) and a compare/capture stage (A1, B1). Transfers between the two stages are timed so that a software read gets a matched pair of values and so that a new period or duty cycle takes effect without a glitch.

The time base used for captures and compares comes from one of three places: the channel's own prescaled counter, a global counter bus or a local counter bus. The channel exports its own counter so that neighbouring channels can use it as their time base. A sticky event flag reports captures, matches and period ends. It is cleared by a write-one-to-clear strobe.

Top module: `tmr_channel`

## Requirements
- R1: After reset, `out_ff`, `flag`, `cnt_out`, `a_data` and `b_data` are all zero.
- R2: In buffered modulus mode (code 1010000), the internal counter counts from 0 up to A1 and then wraps to 0. It advances once every `pre_div`+1 clocks, so one period lasts (A1+1)*(`pre_div`+1) clocks and each wrap raises the flag.
- R3: In buffered modulus mode, a write to A changes only A2. A1 takes the new value at the next wrap, so the current period finishes at the old length.
- R4: In input-pin mode (code 0000000), `pin_level` follows `pin_in` one clock later. When `edge_sel`=0, the flag is raised two clocks after the edge selected by `edge_pol` (1 = rising, 0 = falling), and the other edge is ignored. When `edge_sel`=1, no flag is raised.
- R5: In output-pin mode (code 0000001), `out_ff` copies `edge_pol` one clock later.
- R6: In capture mode (code 0000010), the selected edge copies the time base into A2 (read on `a_data`) and raises the flag. With `edge_sel`=1 both edges capture. With `edge_sel`=0 only the edge chosen by `edge_pol` captures.
- R7: In pulse-width mode (code 0000100), the leading edge (the `edge_pol` edge) stores the time base in B2. The trailing edge stores it in A2 and moves the paired leading value to B1. A trailing edge seen before the first leading edge has no effect.
- R8: In pulse-width mode, an `rd_a` strobe copies A1 (the leading value paired with A2) into B1 and blocks further B2-to-B1 transfers until an `rd_b` strobe. The B value read after A is therefore coherent with it.
- R9: In buffered PWM mode (code 1100000), `out_ff` takes `edge_pol` on mode entry and on an A1 match, and takes its complement on a B1 match (A has priority). A1 and B1 reload from A2 and B2 when the time base is 0, so each period holds `edge_pol` for B-A clocks.
- R10: `bus_sel` picks the time base: 0 selects the internal counter, 1 selects `bus_a` and 2 selects `bus_local`.
- R11: The flag stays set until a `flag_clr` strobe clears it. If a new event arrives in the same cycle as the strobe, the event wins.
- R12: A change of mode code clears A1, A2, B1, B2, the internal counter and the prescaler. It also sets `out_ff` to `edge_pol` when entering PWM mode and to 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 7 | Mode code |
| edge_pol | input | 1 | Edge/output polarity |
| edge_sel | input | 1 | Both-edge select / flag suppress in pin mode |
| bus_sel | input | 2 | Time base select |
| pre_div | input | 2 | Prescaler divide minus one |
| pin_in | input | 1 | Channel input pin (synchronous to clk) |
| bus_a | input | 16 | Global counter bus |
| bus_local | input | 16 | Local counter bus |
| wr_a | input | 1 | Write strobe for A2 |
| wr_b | input | 1 | Write strobe for B2 |
| wr_data | input | 16 | Write data |
| rd_a | input | 1 | Read-A event strobe |
| rd_b | input | 1 | Read-B event strobe |
| flag_clr | input | 1 | Write-one-to-clear flag strobe |
| a_data | output | 16 | Value of register A (A2) |
| b_data | output | 16 | Value of register B (B1 in capture modes, B2 otherwise) |
| cnt_out | output | 16 | Internal counter value |
| pin_level | output | 1 | Registered pin level |
| out_ff | output | 1 | Output flip-flop |
| flag | output | 1 | Sticky event flag |

## Verification
The properties assume that `pin_in` is already synchronous to `clk`. They also assume that `rd_a` and `rd_b` are single-cycle strobes and that the mode code changes only between test phases. The bench drives every input at the falling edge and switches modes only through a task that holds the new code for a full clock. In PWM mode it feeds `bus_a` as a clean ramp from 0 to 15, which keeps every match value inside the period it sweeps.

// File: rtl/tmr_pkg.sv
// Package: shared mode codes and time-base selector values for the timer channel.
// Assumes a 7-bit mode code and a 2-bit time-base selector.
package tmr_pkg;
    localparam int MODE_W = 7;
    localparam int SEL_W  = 2;

    localparam logic [MODE_W-1:0] MD_PIN_IN  = 7'b0000000;
    localparam logic [MODE_W-1:0] MD_PIN_OUT = 7'b0000001;
    localparam logic [MODE_W-1:0] MD_CAPTURE = 7'b0000010;
    localparam logic [MODE_W-1:0] MD_PWIDTH  = 7'b0000100;
    localparam logic [MODE_W-1:0] MD_MODCNT  = 7'b1010000;
    localparam logic [MODE_W-1:0] MD_PWMBUF  = 7'b1100000;

    localparam logic [SEL_W-1:0] TB_INTERNAL = 2'd0;
    localparam logic [SEL_W-1:0] TB_GLOBAL   = 2'd1;
    localparam logic [SEL_W-1:0] TB_LOCAL    = 2'd2;
endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: emits a one-cycle tick every div_sel+1 clocks.
// Assumes restart is a one-cycle pulse; it realigns the tick phase.
module tmr_prescaler #(
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] div_sel,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;

    assign tick = (phase_q == div_sel);

    // Phase counter: runs to div_sel, then returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) phase_q <= '0;
        else if (tick)         phase_q <= '0;
        else                   phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/tmr_edge_detect.sv
// Edge detector: registers the pin and flags rising and falling transitions.
// Assumes pin_in is already synchronous to clk (no glitch filter here).
module tmr_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_level,
    output logic rise,
    output logic fall
);
    logic pin_q, pin_d;

    // Two-stage history of the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
            pin_d <= 1'b0;
        end else begin
            pin_q <= pin_in;
            pin_d <= pin_q;
        end
    end

    assign pin_level = pin_q;
    assign rise      = pin_q & ~pin_d;
    assign fall      = ~pin_q & pin_d;
endmodule

// File: rtl/tmr_counter.sv
// Internal counter: advances on tick; wraps at limit when modulus_en, else at all-ones.
// Assumes restart has priority over tick.
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         tick,
    input  logic         modulus_en,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    assign wrap = tick && (modulus_en ? (count == limit) : (count == ALL_ONES));

    // Count register: restart, modulus wrap, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)    count <= '0;
        else if (wrap)            count <= '0;
        else if (tick)            count <= count + 1'b1;
    end
endmodule

// File: rtl/tmr_channel.sv
// Timer channel: mode-coded capture / compare unit with staged A and B registers.
// Assumes single-cycle rd/wr/clear strobes and a synchronous pin input.
// A change of mode code resets the staged registers, counter and output flip-flop.
module tmr_channel #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [tmr_pkg::MODE_W-1:0] mode,
    input  logic                      edge_pol,
    input  logic                      edge_sel,
    input  logic [tmr_pkg::SEL_W-1:0] bus_sel,
    input  logic [PRE_W-1:0]          pre_div,
    input  logic                      pin_in,
    input  logic [CNT_W-1:0]          bus_a,
    input  logic [CNT_W-1:0]          bus_local,
    input  logic                      wr_a,
    input  logic                      wr_b,
    input  logic [CNT_W-1:0]          wr_data,
    input  logic                      rd_a,
    input  logic                      rd_b,
    input  logic                      flag_clr,
    output logic [CNT_W-1:0]          a_data,
    output logic [CNT_W-1:0]          b_data,
    output logic [CNT_W-1:0]          cnt_out,
    output logic                      pin_level,
    output logic                      out_ff,
    output logic                      flag
);
    import tmr_pkg::*;

    logic [MODE_W-1:0] mode_q;
    logic              chg;
    logic              tick, wrap, rise, fall;
    logic [CNT_W-1:0]  tb;
    logic [CNT_W-1:0]  a1_q, a2_q, b1_q, b2_q;
    logic              seen_q, blk_q;
    logic              is_pin_in, is_pin_out, is_cap, is_pw, is_mod, is_pwm;
    logic              sel_edge, lead_edge, trail_edge;
    logic              pin_flag, cap_hit, pw_lead, pw_trail, mod_wrap;
    logic              pwm_a_hit, pwm_b_hit, pwm_load, set_ev;

    // Remember the mode code to detect a mode switch.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MD_PIN_IN;
        else        mode_q <= mode;
    end
    assign chg = (mode != mode_q);

    assign is_pin_in  = (mode == MD_PIN_IN);
    assign is_pin_out = (mode == MD_PIN_OUT);
    assign is_cap     = (mode == MD_CAPTURE);
    assign is_pw      = (mode == MD_PWIDTH);
    assign is_mod     = (mode == MD_MODCNT);
    assign is_pwm     = (mode == MD_PWMBUF);

    tmr_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk(clk), .rst_n(rst_n), .restart(chg), .div_sel(pre_div), .tick(tick)
    );

    tmr_counter #(.W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .restart(chg), .tick(tick),
        .modulus_en(is_mod), .limit(a1_q), .count(cnt_out), .wrap(wrap)
    );

    tmr_edge_detect i_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .pin_level(pin_level), .rise(rise), .fall(fall)
    );

    // Time-base selector.
    always_comb begin
        case (bus_sel)
            TB_GLOBAL: tb = bus_a;
            TB_LOCAL:  tb = bus_local;
            default:   tb = cnt_out;
        endcase
    end

    // Edge qualification and event decode.
    assign lead_edge  = edge_pol ? rise : fall;
    assign trail_edge = edge_pol ? fall : rise;
    assign sel_edge   = edge_sel ? (rise | fall) : lead_edge;
    assign pin_flag   = is_pin_in & ~edge_sel & lead_edge;
    assign cap_hit    = is_cap & sel_edge;
    assign pw_lead    = is_pw & lead_edge;
    assign pw_trail   = is_pw & trail_edge & seen_q;
    assign mod_wrap   = is_mod & wrap;
    assign pwm_a_hit  = is_pwm & (tb == a1_q);
    assign pwm_b_hit  = is_pwm & (tb == b1_q);
    assign pwm_load   = is_pwm & (tb == '0);
    assign set_ev     = pin_flag | cap_hit | pw_trail | mod_wrap | pwm_b_hit;

    // A2: write stage, also capture target for trailing/selected edges.
    always_ff @(posedge clk) begin
        if (!rst_n || chg)        a2_q <= '0;
        else if (cap_hit)         a2_q <= tb;
        else if (pw_trail)        a2_q <= tb;
        else if (wr_a)            a2_q <= wr_data;
    end

    // B2: write stage, also capture target for leading edges.
    always_ff @(posedge clk) begin
        if (!rst_n || chg)        b2_q <= '0;
        else if (pw_lead)         b2_q <= tb;
        else if (wr_b)            b2_q <= wr_data;
    end

    // A1: compare stage; period/duty reload, or leading value paired with A2.
    always_ff @(posedge clk) begin
        if (!rst_n || chg)        a1_q <= '0;
        else if (pw_trail)        a1_q <= b2_q;
        else if (mod_wrap)        a1_q <= a2_q;
        else if (pwm_load)        a1_q <= a2_q;
    end

    // B1: compare stage; forced from A1 on read-A, otherwise from B2 unless blocked.
    always_ff @(posedge clk) begin
        if (!rst_n || chg)            b1_q <= '0;
        else if (is_pw && rd_a)       b1_q <= a1_q;
        else if (pw_trail && !blk_q)  b1_q <= b2_q;
        else if (pwm_load)            b1_q <= b2_q;
    end

    // Coherency block: set by read-A in pulse-width mode, released by read-B.
    always_ff @(posedge clk) begin
        if (!rst_n || chg)        blk_q <= 1'b0;
        else if (is_pw && rd_a)   blk_q <= 1'b1;
        else if (rd_b)            blk_q <= 1'b0;
    end

    // Arm flag: trailing captures are allowed after the first leading edge.
    always_ff @(posedge clk) begin
        if (!rst_n || chg)        seen_q <= 1'b0;
        else if (pw_lead)         seen_q <= 1'b1;
    end

    // Output flip-flop.
    always_ff @(posedge clk) begin
        if (!rst_n)               out_ff <= 1'b0;
        else if (chg)             out_ff <= (mode == MD_PWMBUF) ? edge_pol : 1'b0;
        else if (is_pin_out)      out_ff <= edge_pol;
        else if (pwm_a_hit)       out_ff <= edge_pol;
        else if (pwm_b_hit)       out_ff <= ~edge_pol;
    end

    // Sticky event flag; a new event beats the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)               flag <= 1'b0;
        else if (set_ev)          flag <= 1'b1;
        else if (flag_clr)        flag <= 1'b0;
    end

    assign a_data = a2_q;
    assign b_data = (is_cap || is_pw) ? b1_q : b2_q;
endmodule

// File: rtl/tmr_channel_chk.sv
// Checker: temporal properties of the timer channel, bound to every instance.
// Assumes it observes the channel's ports plus a few internal stage signals.
module tmr_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [tmr_pkg::MODE_W-1:0] mode,
    input logic                       edge_pol,
    input logic                       rd_a,
    input logic                       rd_b,
    input logic                       flag_clr,
    input logic [CNT_W-1:0]           a_data,
    input logic [CNT_W-1:0]           b_data,
    input logic [CNT_W-1:0]           cnt_out,
    input logic                       out_ff,
    input logic                       flag,
    input logic                       chg,
    input logic                       set_ev,
    input logic                       blk_q,
    input logic [CNT_W-1:0]           a1_q,
    input logic [CNT_W-1:0]           b1_q
);
    import tmr_pkg::*;

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !flag_clr |=> flag);                                          // R11
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !set_ev |=> !flag);                                       // R11
    AST_PIN_OUT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_PIN_OUT) && !chg |=> out_ff == $past(edge_pol));          // R5
    AST_MOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_MODCNT) && !chg |-> cnt_out <= a1_q);                     // R2
    AST_B_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        blk_q && !rd_a && !rd_b && !chg && (mode == MD_PWIDTH) |=> $stable(b1_q)); // R8
    AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (a_data == '0) && (b_data == '0));                            // R12
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) i_tmr_channel_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .edge_pol(edge_pol),
    .rd_a(rd_a), .rd_b(rd_b), .flag_clr(flag_clr),
    .a_data(a_data), .b_data(b_data), .cnt_out(cnt_out),
    .out_ff(out_ff), .flag(flag), .chg(chg), .set_ev(set_ev),
    .blk_q(blk_q), .a1_q(a1_q), .b1_q(b1_q)
);

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  mode = MD_PIN_IN;
    logic        edge_pol = 1'b0, edge_sel = 1'b0;
    logic [1:0]  bus_sel = 2'd0, pre_div = 2'd0;
    logic        pin_in = 1'b0;
    logic [15:0] bus_a = '0, bus_local = '0, wr_data = '0;
    logic        wr_a = 1'b0, wr_b = 1'b0, rd_a = 1'b0, rd_b = 1'b0, flag_clr = 1'b0;
    logic [15:0] a_data, b_data, cnt_out;
    logic        pin_level, out_ff, flag;

    int total = 0;
    int fails = 0;
    int tcnt  = 0;
    int n;

    always #2 clk = ~clk;

    tmr_channel i_tmr_channel (
        .clk(clk), .rst_n(rst_n), .mode(mode), .edge_pol(edge_pol), .edge_sel(edge_sel),
        .bus_sel(bus_sel), .pre_div(pre_div), .pin_in(pin_in), .bus_a(bus_a),
        .bus_local(bus_local), .wr_a(wr_a), .wr_b(wr_b), .wr_data(wr_data),
        .rd_a(rd_a), .rd_b(rd_b), .flag_clr(flag_clr), .a_data(a_data), .b_data(b_data),
        .cnt_out(cnt_out), .pin_level(pin_level), .out_ff(out_ff), .flag(flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic [6:0] m);
        mode = m;
        step();
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] lead, input logic [15:0] trail);
        bus_a = lead;  pin_in = 1'b1; step(); step();
        bus_a = trail; pin_in = 1'b0; step(); step();
    endtask

    task automatic pstep();
        bus_a = 16'(tcnt % 16);
        tcnt++;
        step();
    endtask

    function automatic int a_pick(input int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 3;
            default: return 6;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 out_ff", out_ff, 0);
        chk("R1 flag", flag, 0);
        chk("R1 cnt", cnt_out, 0);
        chk("R1 a_data", a_data, 0);
        chk("R1 b_data", b_data, 0);

        // R4 input-pin mode
        edge_pol = 1'b1;
        pin_in = 1'b1; step();
        chk("R4 pin_level", pin_level, 1);
        step();
        chk("R4 rise flag", flag, 1);
        repeat (3) step();
        chk("R11 sticky", flag, 1);
        clear_flag();
        chk("R11 cleared", flag, 0);
        pin_in = 1'b0; step(); step();
        chk("R4 other edge ignored", flag, 0);
        edge_sel = 1'b1; pin_in = 1'b1; step(); step();
        chk("R4 suppressed", flag, 0);
        edge_sel = 1'b0; edge_pol = 1'b0; pin_in = 1'b0; step(); step();
        chk("R4 fall flag", flag, 1);
        clear_flag();

        // R5 output-pin mode
        edge_pol = 1'b1;
        set_mode(MD_PIN_OUT);
        step();
        chk("R5 out high", out_ff, 1);
        edge_pol = 1'b0; step();
        chk("R5 out low", out_ff, 0);

        // R6 capture, R10 bus select
        bus_sel = TB_GLOBAL; bus_a = 16'h1234; edge_pol = 1'b1; edge_sel = 1'b0;
        set_mode(MD_CAPTURE);
        pin_in = 1'b1; step(); step();
        chk("R6 capture global", a_data, 16'h1234);
        chk("R6 flag", flag, 1);
        clear_flag();
        bus_sel = TB_LOCAL; bus_local = 16'h0BEE; edge_sel = 1'b1;
        pin_in = 1'b0; step(); step();
        chk("R10 capture local both-edge", a_data, 16'h0BEE);
        edge_sel = 1'b0; edge_pol = 1'b0; bus_local = 16'h5555;
        pin_in = 1'b1; step(); step();
        chk("R6 unselected edge ignored", a_data, 16'h0BEE);
        pre_div = 2'd1; bus_sel = TB_INTERNAL;
        set_mode(MD_PIN_IN);
        set_mode(MD_CAPTURE);
        repeat (10) step();
        chk("R2 prescaled internal count", cnt_out, 5);
        pre_div = 2'd0;
        pin_in = 1'b0; step(); step();
        chk("R10 capture internal", a_data, 6);

        // R7 pulse width
        pin_in = 1'b1; step(); step();
        bus_sel = TB_GLOBAL; edge_pol = 1'b1;
        set_mode(MD_PWIDTH);
        clear_flag();
        bus_a = 16'd50; pin_in = 1'b0; step(); step();
        chk("R7 trailing before leading", a_data, 0);
        chk("R7 no flag before leading", flag, 0);
        pulse(16'd100, 16'd250);
        chk("R7 trailing A", a_data, 250);
        chk("R7 leading B", b_data, 100);
        // R8 coherent read
        rd_a = 1'b1; step(); rd_a = 1'b0;
        pulse(16'd300, 16'd450);
        chk("R8 B frozen", b_data, 100);
        chk("R8 A updated", a_data, 450);
        rd_a = 1'b1; step(); rd_a = 1'b0;
        chk("R8 forced pair", b_data, 300);
        rd_b = 1'b1; step(); rd_b = 1'b0;
        pulse(16'd500, 16'd600);
        chk("R8 released A", a_data, 600);
        chk("R8 released B", b_data, 500);

        // R12 mode change clears
        set_mode(MD_CAPTURE);
        chk("R12 A cleared", a_data, 0);
        chk("R12 B cleared", b_data, 0);
        chk("R12 out cleared", out_ff, 0);

        // R2 modulus period sweep
        bus_sel = TB_INTERNAL;
        flag_clr = 1'b1;
        for (int d = 0; d < 4; d++) begin
            for (int i = 0; i < 4; i++) begin
                pre_div = 2'(d);
                set_mode(MD_PIN_IN);
                set_mode(MD_MODCNT);
                wr_a = 1'b1; wr_data = 16'(a_pick(i)); step(); wr_a = 1'b0;
                repeat (60) step();
                while (!flag) step();
                n = 0;
                do begin step(); n++; end while (!flag);
                chk("R2 period", n, (a_pick(i) + 1) * (d + 1));
            end
        end

        // R3 buffered period update
        pre_div = 2'd0;
        set_mode(MD_PIN_IN);
        set_mode(MD_MODCNT);
        wr_a = 1'b1; wr_data = 16'd7; step(); wr_a = 1'b0;
        repeat (30) step();
        while (!flag) step();
        n = 0;
        do begin
            if (n == 2) begin wr_a = 1'b1; wr_data = 16'd2; end
            step();
            wr_a = 1'b0;
            n++;
        end while (!flag);
        chk("R3 old period kept", n, 8);
        n = 0;
        do begin step(); n++; end while (!flag);
        chk("R3 new period", n, 3);
        flag_clr = 1'b0;

        // R9 buffered PWM sweep
        bus_sel = TB_GLOBAL;
        for (int i = 0; i < 4; i++) begin
            int la, tb_, cnt;
            la  = (i == 0) ? 3 : (i == 1) ? 1 : (i == 2) ? 7 : 12;
            tb_ = (i == 0) ? 10 : (i == 1) ? 15 : (i == 2) ? 8 : 14;
            edge_pol = (i % 2 == 0);
            set_mode(MD_PIN_IN);
            mode = MD_PWMBUF; pstep();
            chk("R9 entry level", out_ff, int'(edge_pol));
            wr_a = 1'b1; wr_data = 16'(la);  pstep(); wr_a = 1'b0;
            wr_b = 1'b1; wr_data = 16'(tb_); pstep(); wr_b = 1'b0;
            repeat (40) pstep();
            cnt = 0;
            repeat (16) begin
                pstep();
                if (out_ff == edge_pol) cnt++;
            end
            chk("R9 duty", cnt, tb_ - la);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule